// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block takes a stream of 32-bit command words and groups them into whole command packets for a drawing engine. The top byte of a packet's first word is its opcode, and a computed 256-entry table gives the number of parameter words that follow the opcode. Words collect in a small internal FIFO. A packet is offered downstream only when every one of its words is already buffered. The words then leave back to back over a valid/ready handshake. Each word carries the packet's opcode, its total length, and first/last markers.

Two polyline opcode groups have no fixed length. They end on the first word whose masked value matches a terminator pattern, and the terminator word is included in the packet. A single-word no-op opcode is removed from the stream without ever reaching the output. The eight environment-setting opcodes are forwarded like any other one-word packet. They are also stored whole into a shadow register file, which is exposed on a flat output bus.

Top module: `gfx_packet_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word, and the packet length is one plus the table extra for that opcode. The packet leaves as consecutive words in arrival order. out_first is high only on the first word and out_last only on the final word. Every word shows the packet's opcode and total length.
- R2: Opcodes 0x20–0x3F take an extra count selected by opcode bits 4:2. Selector values 0 through 7 give 3, 6, 4, 8, 5, 8, 7 and 11 respectively.
- R3: The other fixed lengths are as follows. Opcode 0x02 has 2 extras. 0x40–0x47 have 2 and 0x50–0x57 have 3. Among 0x60–0x7F, bits 4:2 = 0..7 give 2, 3, 1, 0, 1, 2, 1, 2. 0x80–0x9F have 3 and 0xA0–0xDF have 2. Every remaining opcode has 0 extras.
- R4: Opcodes 0x48–0x4F are flat polylines. The packet ends at the first word at index 3 or later (index 0 being the opcode word) whose value ANDed with 0xF000F000 equals 0x50005000. Matching words at indices 1 and 2 are ignored.
- R5: Opcodes 0x58–0x5F are shaded polylines. Only even indices of 4 or more are tested for the same terminator, and a matching word at any other index is ignored.
- R6: While fewer words are buffered than the packet at the FIFO head needs, out_valid stays low and nothing is consumed.
- R7: A head word with opcode 0x1F is dropped from the FIFO without raising out_valid.
- R8: When the first word of a packet with opcode 0xE0–0xE7 is accepted downstream, the whole word is written into shadow entry opcode[2:0]. Shadow entry i sits at shadow_o bits 32*i+31:32*i, and no other packet changes the shadow file.
- R9: After synchronous reset the FIFO is empty: in_ready is 1 and out_valid is 0. Each shadow entry i holds 0xE0+i in bits 31:24 and zeros below.
- R10: With DEPTH words buffered, in_ready is low and a word offered on in_valid is discarded.
- R11: While out_valid is high and out_ready low, out_valid, out_data, out_opcode and out_len hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | FIFO can take a word |
| out_valid | output | 1 | Packet word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packet word |
| out_opcode | output | 8 | Opcode of the current packet |
| out_len | output | clog2(DEPTH+1) | Total words in the current packet |
| out_first | output | 1 | First word of the packet |
| out_last | output | 1 | Final word of the packet |
| shadow_o | output | 256 | Eight 32-bit environment shadow entries |

## Verification
The bench builds the framer with the default depth of 16 words. At that depth the longest fixed packet, a 12-word shaded textured quad, fits entirely in the FIFO, so a packet can be held back at its very last word. Sixteen one-word packets with the consumer stalled fill the FIFO, which makes backpressure and the dropping of an extra word observable. The polyline cases place decoy terminator words at positions the requirements say to ignore. Each is then completed by a real terminator that still fits within the 16-word buffer.

// File: rtl/gfx_packet_framer.sv
module gfx_packet_framer #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic [7:0]    out_opcode,
  output logic [LW-1:0] out_len,
  output logic          out_first,
  output logic          out_last,
  output logic [255:0]  shadow_o
);

  localparam logic [31:0] TERM_MASK = 32'hF000_F000;
  localparam logic [31:0] TERM_PAT  = 32'h5000_5000;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] fill;
  logic          busy;
  logic [LW-1:0] remain, cur_len;
  logic [7:0]    cur_op;
  logic [31:0]   shadow [8];

  function automatic logic [3:0] extra_words(input logic [7:0] op);
    case (op[7:5])
      3'd0: return (op == 8'h02) ? 4'd2 : 4'd0;
      3'd1:
        case (op[4:2])
          3'd0: return 4'd3;
          3'd1: return 4'd6;
          3'd2: return 4'd4;
          3'd3: return 4'd8;
          3'd4: return 4'd5;
          3'd5: return 4'd8;
          3'd6: return 4'd7;
          default: return 4'd11;
        endcase
      3'd2:
        case (op[4:3])
          2'd0: return 4'd2;
          2'd3: return 4'd4;
          default: return 4'd3;
        endcase
      3'd3:
        case (op[4:2])
          3'd0: return 4'd2;
          3'd1: return 4'd3;
          3'd3: return 4'd0;
          3'd5: return 4'd2;
          3'd7: return 4'd2;
          default: return 4'd1;
        endcase
      3'd4: return 4'd3;
      3'd5, 3'd6: return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

  wire [31:0] head     = mem[rd_ptr];
  wire [7:0]  hop      = head[31:24];
  wire        flat_pl  = hop[7:3] == 5'b01001;
  wire        shade_pl = hop[7:3] == 5'b01011;
  wire        has_word = fill != '0;
  wire        skip_op  = hop == 8'h1F;

  wire [LW-1:0] fixed_len = LW'(extra_words(hop)) + LW'(1);

  logic          term_found;
  logic [LW-1:0] term_len;

  always_comb begin
    term_found = 1'b0;
    term_len   = '0;
    for (int i = DEPTH - 1; i >= 3; i--) begin
      if (i < int'(fill) &&
          (mem[rd_ptr + AW'(i)] & TERM_MASK) == TERM_PAT &&
          (flat_pl || (shade_pl && i >= 4 && (i % 2) == 0))) begin
        term_found = 1'b1;
        term_len   = LW'(i + 1);
      end
    end
  end

  wire          poly      = flat_pl || shade_pl;
  wire [LW-1:0] hdr_len   = poly ? term_len : fixed_len;
  wire          hdr_ready = poly ? term_found : (fixed_len <= fill);

  assign out_valid  = busy || (has_word && !skip_op && hdr_ready);
  assign out_data   = head;
  assign out_opcode = busy ? cur_op : hop;
  assign out_len    = busy ? cur_len : hdr_len;
  assign out_first  = !busy;
  assign out_last   = busy ? (remain == LW'(1)) : (hdr_len == LW'(1));
  assign in_ready   = fill != LW'(DEPTH);

  wire take = out_valid && out_ready;
  wire drop = !busy && has_word && skip_op;
  wire pop  = take || drop;
  wire push = in_valid && in_ready;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      fill    <= '0;
      busy    <= 1'b0;
      remain  <= '0;
      cur_len <= '0;
      cur_op  <= '0;
      for (int k = 0; k < 8; k++) shadow[k] <= {5'b11100, 3'(k), 24'h0};
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      fill <= fill + LW'(push) - LW'(pop);
      if (take) begin
        if (!busy) begin
          if (hdr_len != LW'(1)) begin
            busy    <= 1'b1;
            remain  <= hdr_len - LW'(1);
            cur_len <= hdr_len;
            cur_op  <= hop;
          end
          if (hop[7:3] == 5'b11100) shadow[hop[2:0]] <= head;
        end else begin
          remain <= remain - LW'(1);
          if (remain == LW'(1)) busy <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_shadow
    assign shadow_o[g*32 +: 32] = shadow[g];
  end

  a_r11_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_opcode) && $stable(out_len));

  a_r1_burst_continues: assert property (@(posedge clk) disable iff (rst)
    take && !out_last |=> out_valid && !out_first && out_opcode == $past(out_opcode) && out_len == $past(out_len));

  a_r7_noop_hidden: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_first |-> out_opcode != 8'h1F);

  a_r4_flat_ends_on_term: assert property (@(posedge clk) disable iff (rst)
    take && out_last && out_opcode[7:3] == 5'b01001 |-> (out_data & TERM_MASK) == TERM_PAT && out_len >= LW'(4));

  a_r5_shaded_ends_on_term: assert property (@(posedge clk) disable iff (rst)
    take && out_last && out_opcode[7:3] == 5'b01011 |-> (out_data & TERM_MASK) == TERM_PAT && out_len >= LW'(5) && out_len[0]);

  a_r8_shadow_quiet: assert property (@(posedge clk) disable iff (rst)
    !(take && out_first && out_opcode[7:3] == 5'b11100) |=> $stable(shadow_o));

endmodule

// File: tb/gfx_packet_framer_tb_top.sv
`timescale 1ns/1ps
module gfx_packet_framer_tb_top;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1, in_valid = 0, out_ready = 0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_first, out_last;
  logic [31:0] out_data;
  logic [7:0] out_opcode;
  logic [LW-1:0] out_len;
  logic [255:0] shadow_o;

  always #4 clk = ~clk;

  gfx_packet_framer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_opcode(out_opcode),
    .out_len(out_len), .out_first(out_first), .out_last(out_last), .shadow_o(shadow_o));

  localparam int NV = 25;
  localparam logic [15:0] VEC [NV] = '{
    16'h0203, 16'h0001, 16'h2004, 16'h2407, 16'h2805, 16'h2C09, 16'h3006, 16'h3409,
    16'h3808, 16'h3C0C, 16'h4003, 16'h5004, 16'h6003, 16'h6404, 16'h6802, 16'h6C01,
    16'h7002, 16'h7403, 16'h7802, 16'h7C03, 16'h8004, 16'hA003, 16'hC003, 16'hE801,
    16'h1001};

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] pkt [16];
  logic [255:0] snap;
  logic [31:0] d0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid = 1; in_data = w;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic recv(input int len, input string tag);
    out_ready = 1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      check(out_valid, tag, "out_valid", 32'(out_valid), 1);
      check(out_first == (k == 0), "R1", "out_first", 32'(out_first), 32'(k == 0));
      check(out_last == (k == len - 1), "R1", "out_last", 32'(out_last), 32'(k == len - 1));
      check(out_len == LW'(len), tag, "out_len", 32'(out_len), 32'(len));
      check(out_opcode == pkt[0][31:24], "R1", "out_opcode", 32'(out_opcode), 32'(pkt[0][31:24]));
      check(out_data == pkt[k], "R1", "out_data", out_data, pkt[k]);
      @(posedge clk); #1;
    end
    out_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(in_ready, "R9", "in_ready", 32'(in_ready), 1);
    check(!out_valid, "R9", "out_valid", 32'(out_valid), 0);
    for (int i = 0; i < 8; i++)
      check(shadow_o[i*32 +: 32] == {8'(8'hE0 + i), 24'h0}, "R9", "shadow",
            shadow_o[i*32 +: 32], {8'(8'hE0 + i), 24'h0});
    @(posedge clk); #1;

    // R2 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      int len;
      len = int'(VEC[v][7:0]);
      pkt[0] = {VEC[v][15:8], 24'h00AB00 + 24'(v)};
      for (int k = 1; k < len; k++) pkt[k] = 32'h0000_0100 + 32'(k);
      for (int k = 0; k < len; k++) push(pkt[k]);
      recv(len, (VEC[v][15:13] == 3'd1) ? "R2" : "R3");
    end

    // R6 hold until the last word of a 9-word packet
    pkt[0] = 32'h2C00_0000;
    for (int k = 1; k < 9; k++) pkt[k] = 32'h0000_0200 + 32'(k);
    for (int k = 0; k < 8; k++) push(pkt[k]);
    @(negedge clk);
    check(!out_valid, "R6", "held out_valid", 32'(out_valid), 0);
    @(posedge clk); #1;
    push(pkt[8]);
    recv(9, "R6");

    // R4 flat polyline, decoy at index 1
    pkt[0] = 32'h4800_0000; pkt[1] = 32'h5000_5000; pkt[2] = 32'h0000_0200;
    pkt[3] = 32'h0000_0300; pkt[4] = 32'h5555_5555;
    for (int k = 0; k < 4; k++) push(pkt[k]);
    @(negedge clk);
    check(!out_valid, "R4", "no early end", 32'(out_valid), 0);
    @(posedge clk); #1;
    push(pkt[4]);
    recv(5, "R4");

    // R5 shaded polyline, decoys at indices 3 and 5
    pkt[0] = 32'h5800_0000; pkt[1] = 32'h0000_0101; pkt[2] = 32'h0000_0202;
    pkt[3] = 32'h5000_5000; pkt[4] = 32'h0000_0404; pkt[5] = 32'h5000_5000;
    pkt[6] = 32'h5FFF_5FFF;
    for (int k = 0; k < 6; k++) push(pkt[k]);
    @(negedge clk);
    check(!out_valid, "R5", "odd index ignored", 32'(out_valid), 0);
    @(posedge clk); #1;
    push(pkt[6]);
    recv(7, "R5");

    // R7 no-op is dropped
    push(32'h1F00_0000);
    repeat (2) @(negedge clk);
    check(!out_valid, "R7", "noop hidden", 32'(out_valid), 0);
    @(posedge clk); #1;
    pkt[0] = 32'h0000_0042;
    push(pkt[0]);
    recv(1, "R7");

    // R8 shadow capture
    snap = shadow_o;
    pkt[0] = 32'hE30A_BCDE;
    push(pkt[0]);
    recv(1, "R8");
    @(negedge clk);
    check(shadow_o[3*32 +: 32] == pkt[0], "R8", "shadow3", shadow_o[3*32 +: 32], pkt[0]);
    check(shadow_o[2*32 +: 32] == snap[2*32 +: 32], "R8", "shadow2", shadow_o[2*32 +: 32], snap[2*32 +: 32]);
    @(posedge clk); #1;
    snap = shadow_o;
    pkt[0] = 32'hE911_1111;
    push(pkt[0]);
    recv(1, "R8");
    @(negedge clk);
    check(shadow_o == snap, "R8", "E9 no capture", shadow_o[31:0], snap[31:0]);
    @(posedge clk); #1;

    // R10 full FIFO, R11 stall hold
    for (int i = 0; i < DEPTH; i++) push(32'h0000_0000 + 32'(i));
    @(negedge clk);
    check(!in_ready, "R10", "in_ready full", 32'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1; in_data = 32'hE500_0077;
    @(posedge clk); #1;
    in_valid = 0;
    @(negedge clk);
    d0 = out_data;
    repeat (3) @(negedge clk);
    check(out_valid && out_data == d0, "R11", "stall hold", out_data, d0);
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH; i++) begin
      pkt[0] = 32'(i);
      recv(1, "R10");
    end
    @(negedge clk);
    check(!out_valid, "R10", "extra word dropped", 32'(out_valid), 0);
    check(shadow_o[5*32 +: 32] == 32'hE500_0000, "R10", "shadow5", shadow_o[5*32 +: 32], 32'hE500_0000);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule